// File: doc/BRIEF.md
# Banked RAM Window Controller

This block gives a CPU an 8-bit data window, 1024 bytes wide, onto a larger backing RAM. A bank register picks which 1024-byte slice of the backing array the window shows. The window has no separate control address: its top offset (all ones, 0x3FF at the default width) also acts as the bank-select register. A write there loads the bank register. The same byte is then stored at that offset inside the newly chosen bank. A read there returns ordinary RAM data.

The CPU side has a read port and a write port that can both be active in the same cycle. Read data comes back one cycle after the request, together with a valid strobe. The backing store is an inferred simple dual-port synchronous RAM. `NUM_BANKS` physical banks are built (four by default). The 8-bit bank value is reduced modulo `NUM_BANKS`, so the unused upper bits alias onto the built banks.

Reset is synchronous and active low. If `cold_rst` is high while reset is held, the reset is cold: the bank register returns to 0 and, once reset releases, a sweep writes zero to every backing location. `ready` stays low during the sweep. If `cold_rst` is low during reset, the reset is warm and leaves the bank register and the RAM untouched.

Top module: `banked_ram_window`

## Requirements
- R1: A CPU access at offset `o` while bank `b` is selected reaches backing location `(b mod NUM_BANKS) * 1024 + o`, so a byte written in one bank is not visible at the same offset of another bank.
- R2: A write at offset 0x3FF loads all 8 data bits into the bank register. The same byte is stored at offset 0x3FF of the newly selected bank.
- R3: A read at offset 0x3FF returns the RAM byte of the current bank, not the bank number.
- R4: An accepted read (`rd_en` high while `ready` is high) drives `rd_valid` high with the data on `rd_data` in the following cycle only. `rd_valid` is low in every other cycle.
- R5: A read issued in the same cycle as a bank-select write is served from the bank selected before that write.
- R6: A read and a write to the same location in the same cycle return the byte held before that write.
- R7: A cold reset sets the bank to 0 and zeroes every backing byte. `ready` stays low for exactly `NUM_BANKS * 1024` cycles after reset releases, and is high afterwards.
- R8: A warm reset keeps the bank register and all RAM contents. `ready` stays high and `rd_valid` is low while reset is held.
- R9: While `ready` is low, reads and writes are ignored: no `rd_valid`, and no change to the bank register.
- R10: Bank values of `NUM_BANKS` or more alias onto bank `value mod NUM_BANKS` (bank 5 shows bank 1 with four banks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_rst | input | 1 | Selects cold (1) or warm (0) reset while `rst_n` is low |
| rd_en | input | 1 | Read request |
| rd_off | input | OFF_W | Read offset within the window |
| wr_en | input | 1 | Write request |
| wr_off | input | OFF_W | Write offset within the window; all ones selects the bank |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, meaningful when `rd_valid` is high |
| rd_valid | output | 1 | Read data strobe, one cycle after an accepted read |
| ready | output | 1 | Low while the cold-reset clear sweep runs |

## Verification
The embedded assertions check three things on every cycle:
- The one-cycle read strobe, and its absence when no read was accepted.
- The bank register loading from a control write and holding still while `ready` is low.
- The clear sweep stepping one address per cycle and ending after the last address.

Only the directed scenarios can show the data-path behaviour:
- Which physical bank a byte lands in, and the aliasing of high bank numbers.
- The write-through at the control offset.
- The old-bank and old-data results of same-cycle read/write pairs.
- That RAM survives a warm reset and reads as zero after a cold one.

// File: rtl/bankwin_pkg.sv
// Shared constants and types for the banked RAM window.
// Assumes byte-wide CPU data and an 8-bit bank register.
package bankwin_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/bankwin_store.sv
// Simple dual-port synchronous RAM used as the backing store.
// Assumes one write port and one read port on the same clock; a read and a
// write to the same address in one cycle return the old contents. The read
// register is not reset: the caller qualifies it with its own valid strobe.
module bankwin_store
    import bankwin_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];
    byte_t rdata_q;

    // Write the array and capture read data (read-before-write order).
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bankwin_clear_seq.sv
// Cold-reset clear sequencer. A cold reset arms it; once reset releases it
// walks every backing address, one per cycle, while `clearing` is high.
// Assumes the very first reset is cold so the state is defined.
module bankwin_clear_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst,
    output logic              clearing,
    output logic [ADDR_W-1:0] clr_addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    logic              busy_q;
    logic [ADDR_W-1:0] ptr_q;

    // Arm on cold reset, hold on warm reset, otherwise step the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_rst) begin
                busy_q <= 1'b1;
                ptr_q  <= '0;
            end
        end else if (busy_q) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign clearing = busy_q;
    assign clr_addr = ptr_q;

    // R7: the sweep advances by exactly one address per cycle.
    a_r7_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ptr_q != LAST) |=> (busy_q && ptr_q == $past(ptr_q) + 1'b1));

    // R7: the sweep ends right after the last address is written.
    a_r7_sweep_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ptr_q == LAST) |=> !busy_q);
endmodule

// File: rtl/bankwin_bank_reg.sv
// Bank-select register and its address decode. A write to the all-ones
// offset loads the bank; that same write targets the new bank, while reads
// in that cycle still use the old one. Only the low PB_W bits pick a
// physical bank. Assumes writes are already gated by `ready`.
module bankwin_bank_reg
    import bankwin_pkg::*;
#(
    parameter int OFF_W = 10,
    parameter int PB_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst,
    input  logic             ready,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  byte_t            wr_data,
    output logic [PB_W-1:0]  rd_bank,
    output logic [PB_W-1:0]  wr_bank
);
    localparam logic [OFF_W-1:0] CTRL_OFF = '1;

    bank_t bank_q;
    logic  ctrl_hit;

    // Decode a bank-select write.
    always_comb begin
        ctrl_hit = ready && wr_en && (wr_off == CTRL_OFF);
    end

    // Bank register: cleared on cold reset, kept on warm reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_rst) begin
                bank_q <= '0;
            end
        end else if (ctrl_hit) begin
            bank_q <= bank_t'(wr_data);
        end
    end

    // Reads use the current bank; writes use the bank that results from them.
    always_comb begin
        rd_bank = bank_q[PB_W-1:0];
        wr_bank = ctrl_hit ? wr_data[PB_W-1:0] : bank_q[PB_W-1:0];
    end

    // R2: a control write loads the whole byte into the bank register.
    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && wr_off == CTRL_OFF) |=> (bank_q == $past(wr_data)));

    // R9: the bank register holds while the block is not ready.
    a_r9_bank_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(bank_q));
endmodule

// File: rtl/banked_ram_window.sv
// Banked RAM window: a 2**OFF_W byte window onto NUM_BANKS banks of backing
// RAM, with the all-ones offset doubling as the bank-select register.
// Assumes NUM_BANKS is a power of two and at least 2, and that the first
// reset is cold. Read data has one cycle of latency.
module banked_ram_window
    import bankwin_pkg::*;
#(
    parameter int OFF_W     = 10,
    parameter int NUM_BANKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] rd_off,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             ready
);
    localparam int PB_W   = $clog2(NUM_BANKS);
    localparam int PHYS_W = PB_W + OFF_W;

    logic              clearing;
    logic [PHYS_W-1:0] clr_addr;
    logic [PB_W-1:0]   rd_bank;
    logic [PB_W-1:0]   wr_bank;
    logic              ram_we;
    logic [PHYS_W-1:0] ram_waddr;
    byte_t             ram_wdata;
    logic              ram_re;
    logic [PHYS_W-1:0] ram_raddr;
    byte_t             ram_rdata;
    logic              rvalid_q;

    bankwin_clear_seq #(.ADDR_W(PHYS_W)) u_clear (
        .clk      (clk),
        .rst_n    (rst_n),
        .cold_rst (cold_rst),
        .clearing (clearing),
        .clr_addr (clr_addr)
    );

    bankwin_bank_reg #(.OFF_W(OFF_W), .PB_W(PB_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cold_rst (cold_rst),
        .ready    (ready),
        .wr_en    (wr_en),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .rd_bank  (rd_bank),
        .wr_bank  (wr_bank)
    );

    // Port arbitration: the clear sweep owns the write port while it runs.
    always_comb begin
        ready     = !clearing;
        ram_re    = rd_en && ready;
        ram_raddr = {rd_bank, rd_off};
        if (clearing) begin
            ram_we    = 1'b1;
            ram_waddr = clr_addr;
            ram_wdata = '0;
        end else begin
            ram_we    = wr_en;
            ram_waddr = {wr_bank, wr_off};
            ram_wdata = wr_data;
        end
    end

    bankwin_store #(.ADDR_W(PHYS_W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // Read strobe, aligned with the registered RAM output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= ram_re;
        end
    end

    assign rd_data  = ram_rdata;
    assign rd_valid = rvalid_q;

    // R4: an accepted read is answered in the next cycle.
    a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready) |=> rd_valid);

    // R4/R9: no strobe without an accepted read.
    a_r4_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && ready) |=> !rd_valid);
endmodule

// File: tb/banked_ram_window_bench.sv
`timescale 1ns/1ps
module banked_ram_window_bench;
    localparam int OFF_W   = 10;
    localparam int NB      = 4;
    localparam int CLR_CYC = NB * (1 << OFF_W);
    localparam logic [OFF_W-1:0] CTRL = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cold_rst = 1'b1;
    logic             rd_en = 1'b0;
    logic [OFF_W-1:0] rd_off = '0;
    logic             wr_en = 1'b0;
    logic [OFF_W-1:0] wr_off = '0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             ready;

    int n_vec = 0;
    int n_bad = 0;

    banked_ram_window #(.OFF_W(OFF_W), .NUM_BANKS(NB)) u_banked_ram_window (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst),
        .rd_en(rd_en), .rd_off(rd_off),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [OFF_W-1:0] o, input logic [7:0] d);
        wr_en = 1'b1; wr_off = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [OFF_W-1:0] o, input logic [7:0] e, input string tag);
        rd_en = 1'b1; rd_off = o;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " data"}, rd_data, e);
    endtask

    task automatic rd_wr_same_cycle(input logic [OFF_W-1:0] ro, input logic [OFF_W-1:0] wo,
                                    input logic [7:0] d, input logic [7:0] e, input string tag);
        rd_en = 1'b1; rd_off = ro;
        wr_en = 1'b1; wr_off = wo; wr_data = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " data"}, rd_data, e);
    endtask

    // R7/R9: cold reset, with a busy-time access probe, and sweep length.
    task automatic t_cold_reset();
        rst_n = 1'b0; cold_rst = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; cold_rst = 1'b0;
        chk("R7 ready low after cold reset", ready, 0);
        chk("R7 no strobe after cold reset", rd_valid, 0);
        rd_en = 1'b1; rd_off = 10'd9;
        wr_en = 1'b1; wr_off = CTRL; wr_data = 8'h03;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R9 read ignored while busy", rd_valid, 0);
        repeat (CLR_CYC - 2) @(negedge clk);
        chk("R7 ready still low on last sweep cycle", ready, 0);
        @(negedge clk);
        chk("R7 ready high after sweep", ready, 1);
    endtask

    task automatic t_basic_banks();
        rd_chk(10'd5, 8'h00, "R7 bank0 zeroed");
        rd_chk(CTRL, 8'h00, "R7 ctrl offset zeroed");
        rd_chk(10'd1000, 8'h00, "R7 high offset zeroed");
        wr(10'd5, 8'hAA);
        wr(CTRL, 8'h01);
        wr(10'd7, 8'h3C);
        rd_chk(10'd5, 8'h00, "R1 bank1 separate from bank0");
        rd_chk(CTRL, 8'h01, "R2 write-through into new bank");
        wr(CTRL, 8'h00);
        rd_chk(10'd5, 8'hAA, "R1 bank0 data kept");
        rd_chk(CTRL, 8'h00, "R3 ctrl read gives RAM byte");
    endtask

    task automatic t_alias();
        wr(CTRL, 8'h05);
        rd_chk(10'd7, 8'h3C, "R10 bank5 aliases bank1");
        rd_chk(CTRL, 8'h05, "R2 full byte stored at ctrl offset");
    endtask

    task automatic t_old_bank_read();
        wr(CTRL, 8'h02);
        wr(10'd9, 8'h99);
        wr(CTRL, 8'h00);
        wr(10'd9, 8'h11);
        rd_wr_same_cycle(10'd9, CTRL, 8'h02, 8'h11, "R5 read uses old bank");
        rd_chk(10'd9, 8'h99, "R5 new bank after switch");
    endtask

    task automatic t_same_location();
        rd_wr_same_cycle(10'd9, 10'd9, 8'h5A, 8'h99, "R6 read returns old byte");
        rd_chk(10'd9, 8'h5A, "R6 write landed");
    endtask

    task automatic t_strobe();
        @(negedge clk);
        chk("R4 no strobe when idle", rd_valid, 0);
        rd_en = 1'b1; rd_off = 10'd9;
        @(negedge clk);
        chk("R4 back-to-back first valid", rd_valid, 1);
        chk("R4 back-to-back first data", rd_data, 8'h5A);
        rd_off = CTRL;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 back-to-back second valid", rd_valid, 1);
        chk("R4 back-to-back second data", rd_data, 8'h02);
        @(negedge clk);
        chk("R4 strobe drops", rd_valid, 0);
    endtask

    task automatic t_warm_reset();
        rst_n = 1'b0; cold_rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 ready high in warm reset", ready, 1);
        chk("R8 no strobe in warm reset", rd_valid, 0);
        rst_n = 1'b1;
        chk("R8 ready high after warm reset", ready, 1);
        rd_chk(10'd9, 8'h5A, "R8 bank and data kept");
        rd_chk(CTRL, 8'h02, "R8 ctrl byte kept");
    endtask

    task automatic t_after_second_cold();
        wr(10'd30, 8'hE1);
        wr(CTRL, 8'h03);
        rd_chk(10'd30, 8'h00, "R9 busy write did not select bank3");
        wr(CTRL, 8'h00);
        rd_chk(10'd30, 8'hE1, "R7 bank back to 0 after cold reset");
        rd_chk(10'd9, 8'h00, "R7 bank0 byte cleared");
        wr(CTRL, 8'h02);
        rd_chk(10'd9, 8'h00, "R7 bank2 byte cleared");
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_cold_reset();
        t_basic_banks();
        t_alias();
        t_old_bank_read();
        t_same_location();
        t_strobe();
        t_warm_reset();
        t_cold_reset();
        t_after_second_cold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule